// File: doc/BRIEF.md
# Four-Channel Block Transfer Engine

This block moves blocks of 16-bit or 32-bit units from one address to another on behalf of a processor. Software programs each of four channels with a source address, a destination address, a unit count and a control word. Setting the enable bit starts the channel. A channel can run at once or wait for a horizontal-blank or a vertical-blank pulse from the display timing logic. Each unit is read and then written through a simple bus master port that holds its request until the memory raises ready.

When more than one channel is waiting, the lowest-numbered one always gets the bus. Arbitration is done again after every unit, so a more urgent channel can take over between two units of a longer block. At the end of a block the channel either switches itself off or, in repeat mode, reloads its count and waits for its next trigger. It can also raise a one-cycle interrupt pulse. The bus port marks the first unit of every block as non-sequential, so that the memory side can charge the longer access time for it.

Top module: `dma4_ctrl`

## Requirements
- R1: Writes to a channel's source or destination address register (cfg_sel 0 and 1) force bit 0 to zero, so every bus address the engine issues is even.
- R2: The count register is selected with cfg_sel 2. With CNT_BITS=16, a written count of 0 means 0x4000 units on channels 0 to 2 and 0x10000 units on channel 3; in general these are 2^(CNT_BITS-2) and 2^CNT_BITS. Reset leaves every count at 2^CNT_BITS.
- R3: Only a write to the control register (cfg_sel 3) that changes enable (bit 15) from 0 to 1 copies source, destination and count into the working registers and arms the channel. In immediate timing, bus_rd rises one cycle after the clock edge that takes the write. Writing the control word again with enable already set copies nothing.
- R4: Control bits 8:7 (source) and 6:5 (destination) select the address step. The codes are 0 increment, 1 decrement, 2 fixed and 3 increment-with-reload. The step is 2 bytes, or 4 bytes when bit 10 (32-bit units) is set.
- R5: On the first unit of a block in 32-bit mode, both addresses are forced down to a multiple of 4.
- R6: When several channels are armed, the lowest-numbered one is serviced first.
- R7: bus_seq is 0 on the first unit of every block and 1 on each later unit.
- R8: When a block ends and repeat (bit 9) is clear, the channel clears its enable bit and control bits 4:0. Its control readback becomes the written value AND 0x7FE0.
- R9: When a block ends and repeat is set, the channel stays enabled and reloads the count. It reloads the destination only in mode 3, keeps the source where it stopped, and waits for its next timing pulse.
- R10: If bit 14 is set, the end of a block raises that channel's irq bit for exactly one cycle. If bit 14 is clear, irq stays low.
- R11: Control bits 13:12 select the timing: 0 immediate, 1 vertical blank, 2 horizontal blank. Code 3 never starts a transfer on channel 0 or on any other channel.
- R12: Blank inputs act on their rising edge. They arm every enabled channel of the matching timing. An edge that comes while a channel is already armed has no effect.
- R13: Every unit is a read followed by a write. bus_rd and bus_wr are never high together, and each holds with a stable address until bus_ready. The written data equals the read data (zero-extended low half in 16-bit mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | IDX_W | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | ADDR_W | Write data |
| ctrl_view | output | NCH*16 | Control register readback, channel i in bits 16i+15:16i |
| hblank | input | 1 | Horizontal-blank pulse |
| vblank | input | 1 | Vertical-blank pulse |
| bus_rd | output | 1 | Read request |
| bus_wr | output | 1 | Write request |
| bus_addr | output | ADDR_W | Byte address of the current request |
| bus_wide | output | 1 | 1 for a 32-bit unit, 0 for 16-bit |
| bus_seq | output | 1 | 0 on the first unit of a block, 1 afterwards |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled when bus_rd and bus_ready are high |
| bus_ready | input | 1 | Memory accepts the current request |
| irq | output | NCH | Per-channel end-of-block pulse |

## Verification
An immediate channel raises bus_rd one cycle after the edge that takes its enable write. A read accepted at an edge turns into a write request on the following cycle. A write accepted at an edge frees the engine, so a new read can appear one cycle later, giving three cycles per unit when ready is held high. The irq pulse and the cleared control readback appear one cycle after the last write is accepted. The bench keeps a queue of expected read/write beats for each scenario and compares every accepted beat at the falling edge, including address, sequential flag, width and data. It checks the arm latency by sampling at the exact cycle, and reads irq counts and the control readback only after the queue has drained and a few cycles have passed.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int BUS_W = 32;
  localparam int CTRL_W = 16;

  localparam int B_EN    = 15;
  localparam int B_IRQ   = 14;
  localparam int B_TM_LO = 12;
  localparam int B_WIDE  = 10;
  localparam int B_RPT   = 9;
  localparam int B_SM_LO = 7;
  localparam int B_DM_LO = 5;

  localparam logic [CTRL_W-1:0] KEEP_MASK = 16'h7FE0;

  typedef enum logic [1:0] {SEL_SRC = 2'd0, SEL_DST = 2'd1, SEL_CNT = 2'd2, SEL_CTRL = 2'd3} cfg_sel_e;
  typedef enum logic [1:0] {AM_INC = 2'd0, AM_DEC = 2'd1, AM_FIX = 2'd2, AM_RELOAD = 2'd3} addr_mode_e;
  typedef enum logic [1:0] {TM_NOW = 2'd0, TM_VBL = 2'd1, TM_HBL = 2'd2, TM_NONE = 2'd3} trig_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} eng_st_e;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_BITS = 16,
  parameter bit LONG_CNT = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [ADDR_W-1:0]   wr_data,
  input  logic                hb_rise,
  input  logic                vb_rise,
  input  logic                unit_done,
  output logic                pend,
  output logic [ADDR_W-1:0]   src_eff,
  output logic [ADDR_W-1:0]   dst_eff,
  output logic                wide,
  output logic                first,
  output logic [CTRL_W-1:0]   ctrl,
  output logic                irq
);
  localparam int CNT_W = CNT_BITS + 1;
  localparam logic [CNT_W-1:0] ONE = 1;
  localparam logic [CNT_W-1:0] ZERO_CNT = LONG_CNT ? (ONE << CNT_BITS) : (ONE << (CNT_BITS - 2));
  localparam logic [CNT_W-1:0] RST_CNT = ONE << CNT_BITS;

  logic [ADDR_W-1:0] src_q, dst_q, wsrc_q, wdst_q, step;
  logic [CNT_W-1:0]  cnt_q, wcnt_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q, first_q, irq_q;
  logic              en, rpt, last, keep_en, blank_arm;
  logic [1:0]        smode, dmode, tmode;

  function automatic logic [ADDR_W-1:0] nxt(input logic [ADDR_W-1:0] a, input logic [1:0] m,
                                            input logic [ADDR_W-1:0] st);
    case (m)
      AM_DEC:  return a - st;
      AM_FIX:  return a;
      default: return a + st;
    endcase
  endfunction

  assign en    = ctrl_q[B_EN];
  assign rpt   = ctrl_q[B_RPT];
  assign wide  = ctrl_q[B_WIDE];
  assign smode = ctrl_q[B_SM_LO +: 2];
  assign dmode = ctrl_q[B_DM_LO +: 2];
  assign tmode = ctrl_q[B_TM_LO +: 2];
  assign step  = wide ? ADDR_W'(4) : ADDR_W'(2);

  assign src_eff = (first_q && wide) ? {wsrc_q[ADDR_W-1:2], 2'b00} : wsrc_q;
  assign dst_eff = (first_q && wide) ? {wdst_q[ADDR_W-1:2], 2'b00} : wdst_q;

  assign last      = (wcnt_q == ONE);
  assign keep_en   = !(unit_done && last && !rpt);
  assign blank_arm = ((hb_rise && tmode == TM_HBL) || (vb_rise && tmode == TM_VBL))
                     && en && keep_en && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      dst_q   <= '0;
      wsrc_q  <= '0;
      wdst_q  <= '0;
      cnt_q   <= RST_CNT;
      wcnt_q  <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (unit_done) begin
        first_q <= 1'b0;
        wsrc_q  <= nxt(src_eff, smode, step);
        wdst_q  <= nxt(dst_eff, dmode, step);
        if (last) begin
          pend_q <= 1'b0;
          irq_q  <= ctrl_q[B_IRQ];
          if (rpt) begin
            wcnt_q <= cnt_q;
            if (dmode == AM_RELOAD) wdst_q <= dst_q;
          end else begin
            ctrl_q <= ctrl_q & KEEP_MASK;
          end
        end else begin
          wcnt_q <= wcnt_q - ONE;
        end
      end
      if (blank_arm) begin
        pend_q  <= 1'b1;
        first_q <= 1'b1;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_SRC: src_q <= {wr_data[ADDR_W-1:1], 1'b0};
          SEL_DST: dst_q <= {wr_data[ADDR_W-1:1], 1'b0};
          SEL_CNT: cnt_q <= (wr_data[CNT_BITS-1:0] == '0) ? ZERO_CNT : {1'b0, wr_data[CNT_BITS-1:0]};
          default: begin
            ctrl_q <= wr_data[CTRL_W-1:0];
            if (!en && wr_data[B_EN]) begin
              wsrc_q  <= src_q;
              wdst_q  <= dst_q;
              wcnt_q  <= cnt_q;
              first_q <= 1'b1;
              pend_q  <= (wr_data[B_TM_LO +: 2] == TM_NOW);
            end else if (!wr_data[B_EN]) begin
              pend_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign pend  = pend_q;
  assign first = first_q;
  assign ctrl  = ctrl_q;
  assign irq   = irq_q;
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NCH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        gnt_any,
  input  logic [IDX_W-1:0]            gnt_idx,
  input  logic [NCH-1:0][ADDR_W-1:0]  src_arr,
  input  logic [NCH-1:0][ADDR_W-1:0]  dst_arr,
  input  logic [NCH-1:0]              wide_arr,
  input  logic [NCH-1:0]              first_arr,
  input  logic                        bus_ready,
  input  logic [BUS_W-1:0]            bus_rdata,
  output logic                        bus_rd,
  output logic                        bus_wr,
  output logic [ADDR_W-1:0]           bus_addr,
  output logic                        bus_wide,
  output logic                        bus_seq,
  output logic [BUS_W-1:0]            bus_wdata,
  output logic [NCH-1:0]              unit_done
);
  localparam logic [NCH-1:0] ONE_HOT0 = 1;

  eng_st_e          st_q;
  logic [IDX_W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cur_q     <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wide  <= 1'b0;
      bus_seq   <= 1'b0;
      bus_wdata <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (gnt_any) begin
          cur_q    <= gnt_idx;
          bus_rd   <= 1'b1;
          bus_addr <= src_arr[gnt_idx];
          bus_wide <= wide_arr[gnt_idx];
          bus_seq  <= !first_arr[gnt_idx];
          st_q     <= ST_RD;
        end
        ST_RD: if (bus_ready) begin
          bus_wdata <= bus_wide ? bus_rdata : {16'h0000, bus_rdata[15:0]};
          bus_rd    <= 1'b0;
          bus_wr    <= 1'b1;
          bus_addr  <= dst_arr[cur_q];
          st_q      <= ST_WR;
        end
        default: if (bus_ready) begin
          bus_wr <= 1'b0;
          st_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign unit_done = (st_q == ST_WR && bus_ready) ? (ONE_HOT0 << cur_q) : '0;
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 32,
  parameter int CNT_BITS = 16,
  localparam int IDX_W   = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [IDX_W-1:0]      cfg_ch,
  input  logic [1:0]            cfg_sel,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic [NCH*CTRL_W-1:0] ctrl_view,
  input  logic                  hblank,
  input  logic                  vblank,
  output logic                  bus_rd,
  output logic                  bus_wr,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_wide,
  output logic                  bus_seq,
  output logic [BUS_W-1:0]      bus_wdata,
  input  logic [BUS_W-1:0]      bus_rdata,
  input  logic                  bus_ready,
  output logic [NCH-1:0]        irq
);
  logic                       hb_q, vb_q, hb_rise, vb_rise;
  logic [NCH-1:0]             pend, wide_arr, first_arr, unit_done;
  logic [NCH-1:0][ADDR_W-1:0] src_arr, dst_arr;
  logic                       gnt_any;
  logic [IDX_W-1:0]           gnt_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_q <= 1'b0;
      vb_q <= 1'b0;
    end else begin
      hb_q <= hblank;
      vb_q <= vblank;
    end
  end
  assign hb_rise = hblank && !hb_q;
  assign vb_rise = vblank && !vb_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma4_chan #(
      .ADDR_W  (ADDR_W),
      .CNT_BITS(CNT_BITS),
      .LONG_CNT(i == NCH - 1)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (cfg_we && (cfg_ch == IDX_W'(i))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .hb_rise  (hb_rise),
      .vb_rise  (vb_rise),
      .unit_done(unit_done[i]),
      .pend     (pend[i]),
      .src_eff  (src_arr[i]),
      .dst_eff  (dst_arr[i]),
      .wide     (wide_arr[i]),
      .first    (first_arr[i]),
      .ctrl     (ctrl_view[i*CTRL_W +: CTRL_W]),
      .irq      (irq[i])
    );
  end

  dma4_arb #(.NCH(NCH)) u_arb (
    .req(pend),
    .any(gnt_any),
    .idx(gnt_idx)
  );

  dma4_engine #(.NCH(NCH), .ADDR_W(ADDR_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .gnt_any  (gnt_any),
    .gnt_idx  (gnt_idx),
    .src_arr  (src_arr),
    .dst_arr  (dst_arr),
    .wide_arr (wide_arr),
    .first_arr(first_arr),
    .bus_ready(bus_ready),
    .bus_rdata(bus_rdata),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wide (bus_wide),
    .bus_seq  (bus_seq),
    .bus_wdata(bus_wdata),
    .unit_done(unit_done)
  );
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wide,
  input logic              bus_seq,
  input logic              bus_ready,
  input logic [NCH-1:0]    irq
);
  p_excl_r13: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr));
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !bus_ready |=> bus_rd && $stable(bus_addr));
  p_wr_hold_r13: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !bus_ready |=> bus_wr && $stable(bus_addr));
  p_rd_to_wr_r13: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_ready |=> bus_wr);
  p_even_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) |-> !bus_addr[0]);
  p_first_align_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd || bus_wr) && bus_wide && !bus_seq |-> bus_addr[1:0] == 2'b00);
  p_irq_single_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(irq));
  p_irq_after_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (|irq) |-> $past(bus_wr && bus_ready));
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (|irq) |=> !(|irq));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wide (bus_wide),
  .bus_seq  (bus_seq),
  .bus_ready(bus_ready),
  .irq      (irq)
);

// File: tb/dma4_ctrl_bench.sv
module dma4_ctrl_bench;
  localparam int NCH = 4;
  localparam int CNT_BITS = 8;
  localparam int SHORT_N = 64;
  localparam int LONG_N = 256;

  typedef struct {
    logic [31:0] ra;
    logic [31:0] wa;
    bit          seq;
    bit          wide;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] ctrl_view;
  logic        hblank = 1'b0, vblank = 1'b0;
  logic        bus_rd, bus_wr, bus_wide, bus_seq, bus_ready;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  irq;
  logic        stall_en = 1'b0;
  logic [7:0]  cyc = '0;

  int nchk = 0, nfail = 0;
  int irq_seen[NCH];
  beat_t exp_q[$];
  string cur_req = "R13";
  logic [31:0] ms, md;
  bit pend_wr = 0;

  always #5 clk = ~clk;

  dma4_ctrl #(.NCH(NCH), .ADDR_W(32), .CNT_BITS(CNT_BITS)) u_dma4_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_view(ctrl_view), .hblank(hblank), .vblank(vblank),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wide(bus_wide),
    .bus_seq(bus_seq), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  function automatic logic [31:0] fmem(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3C3, a[15:0]};
  endfunction

  assign bus_rdata = fmem(bus_addr);
  always_ff @(posedge clk) cyc <= cyc + 8'd1;
  assign bus_ready = !stall_en || cyc[0];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Beat monitor: every accepted beat is compared with the front of the queue
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_rd && bus_wr) check(0, "R13", "read and write together", 32'd1, 32'd0);
      if (bus_rd && bus_ready) begin
        if (exp_q.size() == 0) check(0, cur_req, "unexpected read", bus_addr, 32'hFFFF_FFFF);
        else begin
          check(bus_addr == exp_q[0].ra, cur_req, "read address", bus_addr, exp_q[0].ra);
          check(bus_seq == exp_q[0].seq, "R7", "sequential flag", {31'd0, bus_seq}, {31'd0, exp_q[0].seq});
          check(bus_wide == exp_q[0].wide, "R4", "unit width", {31'd0, bus_wide}, {31'd0, exp_q[0].wide});
          pend_wr = 1;
        end
      end
      if (bus_wr && bus_ready) begin
        if (exp_q.size() == 0 || !pend_wr) check(0, cur_req, "unexpected write", bus_addr, 32'hFFFF_FFFF);
        else begin
          logic [31:0] ed;
          ed = exp_q[0].wide ? fmem(exp_q[0].ra) : {16'h0, exp_q[0].ra[15:0]};
          check(bus_addr == exp_q[0].wa, cur_req, "write address", bus_addr, exp_q[0].wa);
          check(bus_wdata == ed, "R13", "write data", bus_wdata, ed);
          void'(exp_q.pop_front());
          pend_wr = 0;
        end
      end
      for (int c = 0; c < NCH; c++) if (irq[c]) irq_seen[c]++;
    end
  end

  function automatic logic [31:0] stepa(input logic [31:0] a, input int m, input bit w);
    logic [31:0] s;
    s = w ? 32'd4 : 32'd2;
    if (m == 1) return a - s;
    if (m == 2) return a;
    return a + s;
  endfunction

  task automatic push_units(input int n, input bit w, input int sm, input int dm);
    for (int k = 0; k < n; k++) begin
      beat_t b;
      b.ra = (k == 0 && w) ? (ms & ~32'd3) : ms;
      b.wa = (k == 0 && w) ? (md & ~32'd3) : md;
      b.seq = (k != 0);
      b.wide = w;
      exp_q.push_back(b);
      ms = stepa(b.ra, sm, w);
      md = stepa(b.wa, dm, w);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_hb();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, "all expected beats seen", exp_q.size(), 0);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) irq_seen[c] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(ctrl_view == 64'd0, "R8", "control readback after reset", ctrl_view[31:0], 32'd0);
    check(!bus_rd && !bus_wr && irq == 4'd0, "R13", "bus idle after reset",
          {30'd0, bus_rd, bus_wr}, 32'd0);

    // R1 R3 R4 R7 R8 R10: 16-bit increment, immediate, irq on
    cur_req = "R4";
    cfg(0, 0, 32'h0000_1001);
    cfg(0, 1, 32'h0000_2000);
    cfg(0, 2, 32'd3);
    ms = 32'h1000; md = 32'h2000;
    push_units(3, 0, 0, 0);
    cfg(0, 3, 32'h0000_C01F);
    check(bus_rd == 1'b0, "R3", "no request in the write cycle", {31'd0, bus_rd}, 32'd0);
    @(negedge clk);
    check(bus_rd == 1'b1, "R3", "request one cycle after enable", {31'd0, bus_rd}, 32'd1);
    check(bus_addr == 32'h1000, "R1", "source bit 0 cleared", bus_addr, 32'h1000);
    wait_idle("R4");
    check(irq_seen[0] == 1, "R10", "irq pulses on channel 0", irq_seen[0], 1);
    check(ctrl_view[15:0] == 16'h4000, "R8", "control after completion", ctrl_view[15:0], 32'h4000);

    // R5 R4: 32-bit, decrementing source, fixed destination, no irq
    cur_req = "R5";
    cfg(1, 0, 32'h0000_3006);
    cfg(1, 1, 32'h0000_4002);
    cfg(1, 2, 32'd3);
    ms = 32'h3006; md = 32'h4002;
    push_units(3, 1, 1, 2);
    cfg(1, 3, 32'h0000_84C0);
    wait_idle("R5");
    check(irq_seen[1] == 0, "R10", "no irq without irq bit", irq_seen[1], 0);
    check(ctrl_view[31:16] == 16'h04C0, "R8", "channel 1 control after completion",
          ctrl_view[31:16], 32'h04C0);

    // R2: zero count, short and long channels, reset count
    cur_req = "R2";
    cfg(2, 0, 32'h0000_A000);
    cfg(2, 1, 32'h0000_B000);
    cfg(2, 2, 32'd0);
    ms = 32'hA000; md = 32'hB000;
    push_units(SHORT_N, 0, 2, 0);
    cfg(2, 3, 32'h0000_8100);
    wait_idle("R2");
    cfg(3, 0, 32'h0000_C000);
    cfg(3, 1, 32'h0000_D000);
    ms = 32'hC000; md = 32'hD000;
    push_units(LONG_N, 0, 0, 0);
    cfg(3, 3, 32'h0000_8000);
    wait_idle("R2");
    cfg(3, 2, 32'd0);
    ms = 32'hC000; md = 32'hD000;
    push_units(LONG_N, 0, 0, 0);
    cfg(3, 3, 32'h0000_8000);
    wait_idle("R2");

    // R9 R12: repeat on hblank with destination reload
    cur_req = "R12";
    cfg(1, 0, 32'h0000_5000);
    cfg(1, 1, 32'h0000_6000);
    cfg(1, 2, 32'd2);
    cfg(1, 3, 32'h0000_E260);
    repeat (6) @(negedge clk);
    check(bus_rd == 1'b0, "R12", "blank channel waits for its pulse", {31'd0, bus_rd}, 32'd0);
    pulse_vb();
    repeat (6) @(negedge clk);
    check(bus_rd == 1'b0, "R12", "other blank does not arm", {31'd0, bus_rd}, 32'd0);
    ms = 32'h5000; md = 32'h6000;
    push_units(2, 0, 0, 3);
    pulse_hb();
    pulse_hb();
    wait_idle("R12");
    check(irq_seen[1] == 1, "R12", "second edge while armed ignored", irq_seen[1], 1);
    check(ctrl_view[31:16] == 16'hE260, "R9", "repeat keeps channel enabled",
          ctrl_view[31:16], 32'hE260);
    cur_req = "R9";
    md = 32'h6000;
    push_units(2, 0, 0, 3);
    pulse_hb();
    wait_idle("R9");
    check(irq_seen[1] == 2, "R9", "second block completes", irq_seen[1], 2);
    cfg(1, 3, 32'd0);
    cfg(2, 0, 32'h0000_7100);
    cfg(2, 1, 32'h0000_7000);
    cfg(2, 2, 32'd2);
    cfg(2, 3, 32'h0000_9200);
    ms = 32'h7100; md = 32'h7000;
    push_units(2, 0, 0, 0);
    pulse_vb();
    wait_idle("R9");
    push_units(2, 0, 0, 0);
    pulse_vb();
    wait_idle("R9");
    cfg(2, 3, 32'd0);

    // R3: rewriting control with enable set copies nothing
    cur_req = "R3";
    cfg(0, 0, 32'h0000_8000);
    cfg(0, 1, 32'h0000_8800);
    cfg(0, 2, 32'd1);
    cfg(0, 3, 32'h0000_A000);
    cfg(0, 0, 32'h0000_9000);
    cfg(0, 3, 32'h0000_A000);
    ms = 32'h8000; md = 32'h8800;
    push_units(1, 0, 0, 0);
    pulse_hb();
    wait_idle("R3");

    // R6: lowest channel first
    cur_req = "R6";
    cfg(2, 0, 32'h0000_E000);
    cfg(2, 1, 32'h0000_E800);
    cfg(2, 2, 32'd3);
    cfg(2, 3, 32'h0000_A000);
    cfg(1, 0, 32'h0000_F000);
    cfg(1, 1, 32'h0000_F800);
    cfg(1, 2, 32'd2);
    cfg(1, 3, 32'h0000_A000);
    ms = 32'hF000; md = 32'hF800;
    push_units(2, 0, 0, 0);
    ms = 32'hE000; md = 32'hE800;
    push_units(3, 0, 0, 0);
    pulse_hb();
    wait_idle("R6");

    // R11: timing code 3 never starts
    cur_req = "R11";
    cfg(0, 2, 32'd1);
    cfg(0, 3, 32'h0000_B000);
    pulse_hb();
    pulse_vb();
    repeat (10) @(negedge clk);
    check(bus_rd == 1'b0 && exp_q.size() == 0, "R11", "no transfer for timing 3",
          {31'd0, bus_rd}, 32'd0);
    check(ctrl_view[15:0] == 16'hB000, "R11", "channel stays enabled", ctrl_view[15:0], 32'hB000);
    cfg(0, 3, 32'd0);

    // R13: stalled bus with 32-bit units
    cur_req = "R13";
    stall_en = 1'b1;
    cfg(3, 0, 32'h0000_0100);
    cfg(3, 1, 32'h0000_0200);
    cfg(3, 2, 32'd2);
    ms = 32'h0100; md = 32'h0200;
    push_units(2, 1, 0, 0);
    cfg(3, 3, 32'h0000_8400);
    wait_idle("R13");
    stall_en = 1'b0;

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule